// File: doc/BRIEF.md
# Reset-Dominant Switching Sequencer With Non-Overlap Delay

This block sequences one power phase. A phase clock pulse arrives on an input; its falling edge sets an on-demand latch. A digital trip input reports that the modulation ramp has crossed the error level, and it clears that latch. The latched demand drives a small state machine that turns the high-side and low-side gate enables on and off. Whichever enable is on drops first, and the other rises only after a programmable number of fast clock cycles with both off.

Clearing wins over setting, so a trip that is present when a clock edge falls keeps the phase off for that period. Once on, the phase stays on until a trip, so the on-time can run across several clock pulses. A saturate input masks the trip, which gives full duty once a pulse has turned the phase on. A ramp-discharge enable is high whenever the latch is clear, from the trip until the next accepted falling edge.

Top module: `pwm_phase_seq`

## Requirements
- R1: While reset is held and after it, until the sequencer first settles, both gate enables are low and the ramp-discharge enable is high.
- R2: A falling edge of the clock pulse (high in the previous cycle, low in this one) with no active trip sets the latch. The ramp-discharge enable goes low on the next clock edge.
- R3: After the latch is set, the low-side enable drops one cycle later. The high-side enable rises after exactly N further cycles with both enables low, where N is the dead-count input. With N = 0 the two swap on the same edge.
- R4: After the latch is cleared, the high-side enable drops one cycle later. The low-side enable rises after exactly N cycles with both enables low.
- R5: An active trip (trip high, saturate low) raises the ramp-discharge enable on the next edge. It stays high until a later falling edge that has no active trip.
- R6: A trip present in the same cycle as a falling edge keeps the latch clear. The low-side enable stays on and discharge stays high.
- R7: Further falling edges while the latch is set leave the high-side enable on. The on-time spans pulses until a trip arrives.
- R8: While saturate is high, the trip input is ignored. With no falling edge the phase stays off. After a falling edge the high-side enable stays on regardless of the trip.
- R9: The high-side and low-side enables are never high in the same cycle.
- R10: If the latch clears while the sequencer is waiting in the turn-on gap, the high-side enable never rises. The low-side enable returns after N cycles counted from when the abort is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sequencing clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_pulse_i | input | 1 | Phase clock pulse; its falling edge requests turn-on |
| trip_i | input | 1 | Comparator result: ramp above error level, clears the latch |
| saturate_i | input | 1 | Error level above comparator range; masks the trip |
| dead_cnt_i | input | DT_W (8) | Non-overlap time in fast clock cycles, 0 to 255 |
| gate_hi_o | output | 1 | High-side gate enable |
| gate_lo_o | output | 1 | Low-side gate enable |
| ramp_dis_o | output | 1 | Ramp discharge enable |

## Verification
The bench counts the both-off cycles in each direction for dead counts of 0, 1, 3 and 5. An off-by-one counter would give a gap one cycle too long or too short, and a missing zero bypass would insert a spurious idle cycle. It drives a trip together with a falling edge; a set-dominant latch would turn the phase on for one period. It clears the latch in the middle of the turn-on gap; a sequencer without an abort path would still raise the high side briefly. It also holds saturate with a constant trip across several pulses; a design that failed to mask the trip would drop the high side or start discharging the ramp.

// File: rtl/pwm_seq_pkg.sv
package pwm_seq_pkg;
  localparam int unsigned DT_W_DEF = 8;

  typedef enum logic [1:0] {
    PH_LOW  = 2'd0,
    PH_RISE = 2'd1,
    PH_HIGH = 2'd2,
    PH_FALL = 2'd3
  } phase_st_t;
endpackage

// File: rtl/pwm_edge_det.sv
module pwm_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sig_i;
  end

  assign fall_o = prev_q & ~sig_i;
endmodule

// File: rtl/pwm_reset_latch.sv
module pwm_reset_latch (
  input  logic clk,
  input  logic rst,
  input  logic fall_i,
  input  logic trip_i,
  input  logic saturate_i,
  output logic on_o,
  output logic ramp_dis_o
);
  logic kill;
  logic on_q;
  logic dis_q;

  assign kill = trip_i & ~saturate_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      on_q  <= 1'b0;
      dis_q <= 1'b1;
    end else if (kill) begin
      on_q  <= 1'b0;
      dis_q <= 1'b1;
    end else if (fall_i) begin
      on_q  <= 1'b1;
      dis_q <= 1'b0;
    end
  end

  assign on_o       = on_q;
  assign ramp_dis_o = dis_q;

  AST_KILL_CLEARS: assert property (@(posedge clk) disable iff (rst)
    kill |=> !on_o); // R6
  AST_KILL_DISCHARGE: assert property (@(posedge clk) disable iff (rst)
    kill |=> ramp_dis_o); // R5
  AST_FALL_SETS: assert property (@(posedge clk) disable iff (rst)
    (fall_i && !kill) |=> (on_o && !ramp_dis_o)); // R2
  AST_SAT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (saturate_i && on_o) |=> on_o); // R8
endmodule

// File: rtl/pwm_deadtime_fsm.sv
module pwm_deadtime_fsm
  import pwm_seq_pkg::*;
#(
  parameter int unsigned DT_W = DT_W_DEF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            demand_i,
  input  logic [DT_W-1:0] dead_i,
  output logic            gate_hi_o,
  output logic            gate_lo_o
);
  localparam logic [DT_W-1:0] CNT_ONE = DT_W'(1);

  phase_st_t       st_q, st_n;
  logic [DT_W-1:0] cnt_q, cnt_n;
  logic            hi_q, lo_q;
  logic            no_gap;

  assign no_gap = (dead_i == '0);

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    unique case (st_q)
      PH_LOW: begin
        if (demand_i) begin
          if (no_gap) st_n = PH_HIGH;
          else begin
            st_n  = PH_RISE;
            cnt_n = CNT_ONE;
          end
        end
      end
      PH_RISE: begin
        if (!demand_i) begin
          st_n  = PH_FALL;
          cnt_n = CNT_ONE;
        end else if (cnt_q >= dead_i) begin
          st_n = PH_HIGH;
        end else begin
          cnt_n = cnt_q + CNT_ONE;
        end
      end
      PH_HIGH: begin
        if (!demand_i) begin
          if (no_gap) st_n = PH_LOW;
          else begin
            st_n  = PH_FALL;
            cnt_n = CNT_ONE;
          end
        end
      end
      PH_FALL: begin
        if (demand_i) begin
          st_n  = PH_RISE;
          cnt_n = CNT_ONE;
        end else if (cnt_q >= dead_i) begin
          st_n = PH_LOW;
        end else begin
          cnt_n = cnt_q + CNT_ONE;
        end
      end
      default: st_n = PH_FALL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= PH_FALL;
      cnt_q <= CNT_ONE;
      hi_q  <= 1'b0;
      lo_q  <= 1'b0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      hi_q  <= (st_n == PH_HIGH);
      lo_q  <= (st_n == PH_LOW);
    end
  end

  assign gate_hi_o = hi_q;
  assign gate_lo_o = lo_q;

  AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (rst)
    !(gate_hi_o && gate_lo_o)); // R9
  AST_HI_AFTER_GAP: assert property (@(posedge clk) disable iff (rst)
    ($rose(gate_hi_o) && $past(dead_i) != '0) |-> !$past(gate_lo_o)); // R3
  AST_LO_AFTER_GAP: assert property (@(posedge clk) disable iff (rst)
    ($rose(gate_lo_o) && $past(dead_i) != '0) |-> !$past(gate_hi_o)); // R4
  AST_ABORT_NO_HI: assert property (@(posedge clk) disable iff (rst)
    (st_q == PH_RISE && !demand_i) |=> !gate_hi_o); // R10
endmodule

// File: rtl/pwm_phase_seq.sv
module pwm_phase_seq
  import pwm_seq_pkg::*;
#(
  parameter int unsigned DT_W = DT_W_DEF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clk_pulse_i,
  input  logic            trip_i,
  input  logic            saturate_i,
  input  logic [DT_W-1:0] dead_cnt_i,
  output logic            gate_hi_o,
  output logic            gate_lo_o,
  output logic            ramp_dis_o
);
  logic fall;
  logic demand;

  pwm_edge_det u_edge (
    .clk    (clk),
    .rst    (rst),
    .sig_i  (clk_pulse_i),
    .fall_o (fall)
  );

  pwm_reset_latch u_latch (
    .clk        (clk),
    .rst        (rst),
    .fall_i     (fall),
    .trip_i     (trip_i),
    .saturate_i (saturate_i),
    .on_o       (demand),
    .ramp_dis_o (ramp_dis_o)
  );

  pwm_deadtime_fsm #(.DT_W(DT_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .demand_i  (demand),
    .dead_i    (dead_cnt_i),
    .gate_hi_o (gate_hi_o),
    .gate_lo_o (gate_lo_o)
  );

  AST_RESET_SAFE: assert property (@(posedge clk)
    $past(rst) |-> (!gate_hi_o && !gate_lo_o && ramp_dis_o)); // R1
endmodule

// File: tb/pwm_phase_seq_test.sv
module pwm_phase_seq_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pulse = 1'b1;
  logic       trip = 1'b0;
  logic       sat = 1'b0;
  logic [7:0] dead = 8'd3;
  logic       hi, lo, rd;
  int         n_chk = 0;
  int         n_bad = 0;
  int         both_hits = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  pwm_phase_seq uut (
    .clk(clk), .rst(rst), .clk_pulse_i(pulse), .trip_i(trip),
    .saturate_i(sat), .dead_cnt_i(dead),
    .gate_hi_o(hi), .gate_lo_o(lo), .ramp_dis_o(rd)
  );

  always @(negedge clk) if (!rst && hi && lo) both_hits++;

  task automatic check(input string req, input logic [2:0] exp);
    n_chk++;
    if ({hi, lo, rd} !== exp) begin
      n_bad++;
      $display("FAIL %s: {hi,lo,rd} actual %b expected %b at %0t", req, {hi, lo, rd}, exp, $time);
    end
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", 3'b001);
    rst = 1'b0;
    @(negedge clk);
    check("R1", 3'b001);
    settle();
    check("R1", 3'b011);
  endtask

  task automatic turn_on(input int n);
    @(negedge clk); pulse = 1'b0;
    @(negedge clk); check("R2", 3'b010); pulse = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); check("R3", 3'b000);
    end
    @(negedge clk); check("R3", 3'b100);
  endtask

  task automatic turn_off(input int n);
    @(negedge clk); trip = 1'b1;
    @(negedge clk); check("R5", 3'b101); trip = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); check("R4", 3'b001);
    end
    @(negedge clk); check("R4", 3'b011);
  endtask

  task automatic t_gaps();
    for (int k = 0; k < 4; k++) begin
      int n;
      n = (k == 0) ? 3 : (k == 1) ? 0 : (k == 2) ? 1 : 5;
      dead = 8'(n);
      settle();
      turn_on(n);
      repeat (4) @(negedge clk);
      check("R3", 3'b100);
      turn_off(n);
      repeat (3) @(negedge clk);
      check("R5", 3'b011);
    end
  endtask

  task automatic t_dominance();
    dead = 8'd2;
    settle();
    @(negedge clk); pulse = 1'b0; trip = 1'b1;
    @(negedge clk); check("R6", 3'b011); pulse = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); check("R6", 3'b011);
    end
    trip = 1'b0;
    repeat (3) @(negedge clk);
    check("R6", 3'b011);
  endtask

  task automatic t_span();
    dead = 8'd2;
    settle();
    turn_on(2);
    for (int p = 0; p < 3; p++) begin
      @(negedge clk); pulse = 1'b0;
      repeat (3) begin
        @(negedge clk); check("R7", 3'b100);
      end
      pulse = 1'b1;
      repeat (3) @(negedge clk);
      check("R7", 3'b100);
    end
    turn_off(2);
  endtask

  task automatic t_saturate();
    dead = 8'd2;
    settle();
    @(negedge clk); sat = 1'b1; trip = 1'b1;
    repeat (4) @(negedge clk);
    check("R8", 3'b011);
    turn_on(2);
    for (int p = 0; p < 3; p++) begin
      @(negedge clk); pulse = 1'b0;
      @(negedge clk); pulse = 1'b1;
      repeat (5) @(negedge clk);
      check("R8", 3'b100);
    end
    @(negedge clk); sat = 1'b0;
    @(negedge clk); check("R8", 3'b101); trip = 1'b0;
    repeat (2) begin
      @(negedge clk); check("R8", 3'b001);
    end
    @(negedge clk); check("R8", 3'b011);
  endtask

  task automatic t_abort();
    dead = 8'd5;
    settle();
    @(negedge clk); pulse = 1'b0;
    @(negedge clk); check("R10", 3'b010); pulse = 1'b1;
    @(negedge clk); check("R10", 3'b000); trip = 1'b1;
    @(negedge clk); check("R10", 3'b001); trip = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); check("R10", 3'b001);
    end
    @(negedge clk); check("R10", 3'b011);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_gaps();
    t_dominance();
    t_span();
    t_saturate();
    t_abort();
    n_chk++;
    if (both_hits != 0) begin
      n_bad++;
      $display("FAIL R9: both-high cycles actual %0d expected 0", both_hits);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule